// File: doc/BRIEF.md
# Trace Acquisition Sequencer

This block sequences one trace acquisition for a logic-analysis capture path. It sits between a pattern-matching unit, which reports trigger hits, and a trace memory, which reports when it is full. From host commands it moves through four states: idle, armed, triggered and stopped. It drives the record-enable strobe that tells the memory when to store a sample. It also drives a one-cycle clear strobe for the memory and a 2-bit state code.

Two buffer policies are supported. In ring mode the memory keeps overwriting itself, so the newest samples before the stop are kept, and the full flag is ignored. In fill-once mode recording stops as soon as the memory reports full. After a trigger, a programmable post-trigger count decides how many more samples are stored before the acquisition stops. Captured data may be read only while the block is idle or stopped.

Top module: `trace_seq_ctrl`

## Requirements
- R1: After reset the state code is 2'b00 (idle), `rec_en` is 0, `rec_clear` is 0 and `rd_ok` is 1.
- R2: `rec_en` is 1 only while the state is armed or triggered. In ring mode (`mode_fill`=0) it stays 1 in those states even when `buf_full` is 1.
- R3: The state codes are 2'b00 idle, 2'b01 armed, 2'b10 triggered and 2'b11 stopped. `cmd_arm` moves idle or stopped to armed on the next cycle. In armed or triggered it has no effect.
- R4: While armed, either `trig_hit` or `cmd_trig` with `post_dly` > 0 moves the block to triggered on the next cycle. Both inputs have no effect in idle or stopped.
- R5: The triggered state lasts exactly `post_dly` cycles, with one record stored in each, and then moves to stopped. When `post_dly` is 0, a trigger moves the block from armed straight to stopped.
- R6: In fill-once mode (`mode_fill`=1), `buf_full` in armed or triggered drops `rec_en` in that same cycle, and the state becomes stopped on the next cycle.
- R7: `cmd_init` produces `rec_clear`=1 for exactly one cycle on the next cycle, puts the block in idle and restarts the post-trigger count. `cmd_test` does the same but puts the block in armed.
- R8: `cmd_off` puts the block in idle on the next cycle from any state. It takes priority over every other command; below it the order is test, init, arm, trigger.
- R9: `rd_ok` is 1 exactly when the state is idle or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_arm | input | 1 | Host command: start an acquisition |
| cmd_off | input | 1 | Host command: go idle |
| cmd_init | input | 1 | Host command: clear memory, restart counts, go idle |
| cmd_test | input | 1 | Host command: clear memory, restart counts, arm |
| cmd_trig | input | 1 | Host command: manual trigger |
| trig_hit | input | 1 | Trigger match from the pattern unit |
| buf_full | input | 1 | Trace memory full flag |
| mode_fill | input | 1 | 1 = fill-once (stack) policy, 0 = ring (FIFO) policy |
| post_dly | input | DLY_W | Records stored after the trigger before stopping |
| rec_en | output | 1 | Store the current sample in the trace memory |
| rec_clear | output | 1 | One-cycle clear strobe for the trace memory |
| state_o | output | 2 | Current state code |
| rd_ok | output | 1 | Captured data may be read |

## Verification
The bench builds the block with `DLY_W` = 4, so every post-trigger count from 0 to 15 can be swept. For each count the bench measures the exact number of triggered cycles and records. The sweep alternates between the pattern hit and the manual trigger, and keeps `buf_full` high, which also shows that the ring policy ignores the full flag. The small width also lets the bench restart a count part way through and check that the next trigger runs the full count again.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_TRIGD = 2'b10,
        ST_STOP  = 2'b11
    } seq_state_e;

    typedef enum logic [2:0] {
        HC_NONE,
        HC_OFF,
        HC_TEST,
        HC_INIT,
        HC_ARM
    } host_cmd_e;

    typedef struct packed {
        seq_state_e st;
        logic       clr;
    } seq_regs_t;

endpackage

// File: rtl/trace_cmd_pick.sv
module trace_cmd_pick
    import trace_seq_pkg::*;
(
    input  logic      cmd_arm,
    input  logic      cmd_off,
    input  logic      cmd_init,
    input  logic      cmd_test,
    input  logic      cmd_trig,
    input  logic      trig_hit,
    output host_cmd_e cmd_sel,
    output logic      trig_any
);
    // Fixed priority: off, test, init, arm.
    always_comb begin
        if (cmd_off)       cmd_sel = HC_OFF;
        else if (cmd_test) cmd_sel = HC_TEST;
        else if (cmd_init) cmd_sel = HC_INIT;
        else if (cmd_arm)  cmd_sel = HC_ARM;
        else               cmd_sel = HC_NONE;
    end

    assign trig_any = trig_hit | cmd_trig;
endmodule

// File: rtl/trace_post_dly.sv
module trace_post_dly #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         at_last
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // True while the current record is the last one of the post-trigger window.
    assign at_last = (cnt_q == limit - ONE);
endmodule

// File: rtl/trace_seq_ctrl.sv
module trace_seq_ctrl
    import trace_seq_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_arm,
    input  logic             cmd_off,
    input  logic             cmd_init,
    input  logic             cmd_test,
    input  logic             cmd_trig,
    input  logic             trig_hit,
    input  logic             buf_full,
    input  logic             mode_fill,
    input  logic [DLY_W-1:0] post_dly,
    output logic             rec_en,
    output logic             rec_clear,
    output logic [1:0]       state_o,
    output logic             rd_ok
);
    seq_regs_t r_d, r_q;
    host_cmd_e cmd_sel;
    logic      trig_any;
    logic      dly_clr, dly_step, dly_last;
    logic      active, full_stop;

    trace_cmd_pick u_pick (
        .cmd_arm  (cmd_arm),
        .cmd_off  (cmd_off),
        .cmd_init (cmd_init),
        .cmd_test (cmd_test),
        .cmd_trig (cmd_trig),
        .trig_hit (trig_hit),
        .cmd_sel  (cmd_sel),
        .trig_any (trig_any)
    );

    trace_post_dly #(.W(DLY_W)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (dly_clr),
        .step    (dly_step),
        .limit   (post_dly),
        .at_last (dly_last)
    );

    assign active    = (r_q.st == ST_ARMED) || (r_q.st == ST_TRIGD);
    assign full_stop = mode_fill && buf_full;

    always_comb begin
        r_d      = r_q;
        r_d.clr  = 1'b0;
        dly_clr  = 1'b0;
        dly_step = 1'b0;
        unique case (cmd_sel)
            HC_OFF: begin
                r_d.st  = ST_IDLE;
                dly_clr = 1'b1;
            end
            HC_TEST: begin
                r_d.st  = ST_ARMED;
                r_d.clr = 1'b1;
                dly_clr = 1'b1;
            end
            HC_INIT: begin
                r_d.st  = ST_IDLE;
                r_d.clr = 1'b1;
                dly_clr = 1'b1;
            end
            default: begin
                unique case (r_q.st)
                    ST_IDLE, ST_STOP: begin
                        if (cmd_sel == HC_ARM) begin
                            r_d.st  = ST_ARMED;
                            dly_clr = 1'b1;
                        end
                    end
                    ST_ARMED: begin
                        if (full_stop) begin
                            r_d.st = ST_STOP;
                        end else if (trig_any) begin
                            dly_clr = 1'b1;
                            r_d.st  = (post_dly == '0) ? ST_STOP : ST_TRIGD;
                        end
                    end
                    ST_TRIGD: begin
                        if (full_stop) begin
                            r_d.st = ST_STOP;
                        end else begin
                            dly_step = 1'b1;
                            if (dly_last) r_d.st = ST_STOP;
                        end
                    end
                    default: r_d.st = ST_IDLE;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.clr <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rec_en    = active && !full_stop;
    assign rec_clear = r_q.clr;
    assign state_o   = r_q.st;
    assign rd_ok     = !active;
endmodule

// File: rtl/trace_seq_chk.sv
module trace_seq_chk #(
    parameter int DLY_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_arm,
    input logic             cmd_off,
    input logic             cmd_init,
    input logic             cmd_test,
    input logic             trig_hit,
    input logic             buf_full,
    input logic             mode_fill,
    input logic [DLY_W-1:0] post_dly,
    input logic             rec_en,
    input logic             rec_clear,
    input logic [1:0]       state_o,
    input logic             rd_ok
);
    logic no_cmd;
    assign no_cmd = !cmd_off && !cmd_init && !cmd_test;

    p_rec_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |-> (state_o == 2'b01 || state_o == 2'b10));

    p_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> !rec_en);

    p_off_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_off |=> (state_o == 2'b00));

    p_fill_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fill && buf_full && no_cmd && (state_o == 2'b01 || state_o == 2'b10))
        |=> (state_o == 2'b11));

    p_trig_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01 && trig_hit && post_dly != '0 && no_cmd && !(mode_fill && buf_full))
        |=> (state_o == 2'b10));

    p_clear_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_init && !cmd_off) |=> rec_clear);

    p_arm_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_arm && no_cmd && (state_o == 2'b00 || state_o == 2'b11)) |=> (state_o == 2'b01));
endmodule

bind trace_seq_ctrl trace_seq_chk #(.DLY_W(DLY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_arm   (cmd_arm),
    .cmd_off   (cmd_off),
    .cmd_init  (cmd_init),
    .cmd_test  (cmd_test),
    .trig_hit  (trig_hit),
    .buf_full  (buf_full),
    .mode_fill (mode_fill),
    .post_dly  (post_dly),
    .rec_en    (rec_en),
    .rec_clear (rec_clear),
    .state_o   (state_o),
    .rd_ok     (rd_ok)
);

// File: tb/trace_seq_ctrl_test.sv
module trace_seq_ctrl_test;
    localparam int DW = 4;
    localparam logic [1:0] S_IDLE = 2'b00, S_ARM = 2'b01, S_TRG = 2'b10, S_STP = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_arm = 0, cmd_off = 0, cmd_init = 0, cmd_test = 0, cmd_trig = 0;
    logic trig_hit = 0, buf_full = 0, mode_fill = 0;
    logic [DW-1:0] post_dly = '0;
    logic rec_en, rec_clear, rd_ok;
    logic [1:0] state_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    trace_seq_ctrl #(.DLY_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_arm(cmd_arm), .cmd_off(cmd_off),
        .cmd_init(cmd_init), .cmd_test(cmd_test), .cmd_trig(cmd_trig),
        .trig_hit(trig_hit), .buf_full(buf_full), .mode_fill(mode_fill),
        .post_dly(post_dly), .rec_en(rec_en), .rec_clear(rec_clear),
        .state_o(state_o), .rd_ok(rd_ok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        cmd_arm = 0; cmd_off = 0; cmd_init = 0; cmd_test = 0; cmd_trig = 0; trig_hit = 0;
    endtask

    // One clock: inputs already set at a falling edge; advance to the next falling edge.
    task automatic tick();
        @(negedge clk);
        quiet();
        #1;
    endtask

    // Counts the cycles spent in the triggered state and checks the record strobe in each.
    task automatic count_trig(input int d, input string tag);
        int n = 0;
        while (state_o == S_TRG && n < 40) begin
            chk({tag, " rec in triggered"}, rec_en, 1);
            n++;
            tick();
        end
        chk({tag, " triggered length"}, n, d);
        chk({tag, " stopped after window"}, state_o, S_STP);
    endtask

    initial begin
        quiet();
        repeat (2) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 state", state_o, S_IDLE);
        chk("R1 rec_en", rec_en, 0);
        chk("R1 rec_clear", rec_clear, 0);
        chk("R1 rd_ok", rd_ok, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R4 trigger ignored while idle
        trig_hit = 1; tick();
        chk("R4 trig ignored in idle", state_o, S_IDLE);

        // Ring-mode sweep over every post-trigger count, full flag held high.
        mode_fill = 0; buf_full = 1;
        for (int d = 0; d < 16; d++) begin
            post_dly = DW'(d);
            cmd_arm = 1; tick();
            chk("R3 arm enters armed", state_o, S_ARM);
            chk("R2 ring ignores full", rec_en, 1);
            chk("R9 rd_ok low armed", rd_ok, 0);
            cmd_arm = 1; tick();
            chk("R3 arm ignored in armed", state_o, S_ARM);
            if (d % 2 == 0) trig_hit = 1; else cmd_trig = 1;
            tick();
            count_trig(d, "R5");
            chk("R9 rd_ok in stopped", rd_ok, 1);
            chk("R2 no rec in stopped", rec_en, 0);
            trig_hit = 1; tick();
            chk("R4 trig ignored in stopped", state_o, S_STP);
        end
        buf_full = 0;

        // R3 arm ignored while triggered
        post_dly = 4'd6;
        cmd_arm = 1; tick();
        trig_hit = 1; tick();
        cmd_arm = 1; tick();
        chk("R3 arm ignored in triggered", state_o, S_TRG);
        count_trig(5, "R3 window continues");

        // R6 fill-once mode stop while armed
        mode_fill = 1;
        cmd_arm = 1; tick();
        buf_full = 1; #1;
        chk("R6 rec drops same cycle", rec_en, 0);
        tick();
        chk("R6 stopped after full armed", state_o, S_STP);
        buf_full = 0;

        // R6 fill-once stop while triggered
        post_dly = 4'd10;
        cmd_arm = 1; tick();
        trig_hit = 1; tick();
        tick(); tick(); tick();
        chk("R6 still triggered", state_o, S_TRG);
        buf_full = 1; #1;
        chk("R6 rec drops in triggered", rec_en, 0);
        tick();
        chk("R6 stopped after full triggered", state_o, S_STP);
        buf_full = 0;
        mode_fill = 0;

        // R7 init from stopped
        cmd_init = 1; tick();
        chk("R7 init clear pulse", rec_clear, 1);
        chk("R7 init to idle", state_o, S_IDLE);
        tick();
        chk("R7 clear single cycle", rec_clear, 0);

        // R7 test mid-window restarts the count
        post_dly = 4'd5;
        cmd_arm = 1; tick();
        trig_hit = 1; tick();
        tick(); tick();
        cmd_test = 1; tick();
        chk("R7 test to armed", state_o, S_ARM);
        chk("R7 test clear pulse", rec_clear, 1);
        cmd_trig = 1; tick();
        chk("R7 clear single cycle after test", rec_clear, 0);
        count_trig(5, "R7 restarted window");

        // R8 off from each state and priority over arm
        cmd_off = 1; tick();
        chk("R8 off from stopped", state_o, S_IDLE);
        cmd_arm = 1; tick();
        cmd_off = 1; tick();
        chk("R8 off from armed", state_o, S_IDLE);
        cmd_arm = 1; tick();
        trig_hit = 1; tick();
        cmd_off = 1; cmd_test = 1; cmd_arm = 1; tick();
        chk("R8 off from triggered wins", state_o, S_IDLE);
        chk("R8 off beats test clear", rec_clear, 0);
        chk("R9 rd_ok idle", rd_ok, 1);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule